// File: doc/BRIEF.md
# Dual-Framing Serial ADC Sample Reader

This block runs on the host side of a 16-bit serial converter and fetches one sample per frame. It drives the converter's serial clock, chip-select and frame-sync lines, and shifts in the returned data. The serial clock comes from the system clock through a divider. Each bit is captured on the falling clock edge, most significant bit first. Once the last bit is in, the word is presented on `sample` together with a one-cycle `sample_valid` strobe.

Two framing styles are available, and the `dsp_mode` input picks one at the moment a frame is accepted:

- **Chip-select framing:** the chip-select strobe alone marks the frame.
- **Frame-sync framing:** chip-select is pulled low first, then a short frame-sync pulse opens the frame.

The converter starts a conversion on the final falling clock edge and reports it on its busy line. The reader does not open a new frame until busy has been low, and the frame has been over, for a programmable number of cycles. Opening a frame too early would abort that conversion. A caller may also cancel a frame once enough of it has elapsed. The reader then drops the frame, reports it on `abort_done` and withholds the sample.

Top module: `adc_frame_reader`

## Requirements
- R1: While `rst_n` is low and after it is released, `adc_cs_n` is 1 and `adc_fs`, `adc_sclk`, `sample_valid` and `abort_done` are 0. `sample` resets to 0.
- R2: A frame is accepted on a clock edge where the reader is idle and both `start` and ready (R6) hold. On that edge `adc_cs_n` goes to 0. In chip-select framing it stays 0 until the edge that raises `sample_valid`, which comes HOLD cycles after the 16th falling serial edge.
- R3: In frame-sync framing (`dsp_mode`=1 at acceptance), `adc_fs` rises CS_SETUP cycles after `adc_cs_n` falls and stays high for FS_WIDTH cycles. The first serial clock phase starts on the edge where `adc_fs` falls. `adc_fs` is never 1 while `adc_cs_n` is 1.
- R4: `adc_sclk` idles at 0. A frame has exactly 16 serial periods, each DIV cycles low followed by DIV cycles high. The clock starts low and is never 1 while `adc_cs_n` is 1.
- R5: `adc_sdo` is sampled on each falling serial edge and shifted in MSB first. `sample` then takes the 16-bit word and `sample_valid` is 1 for one cycle, on the same edge that returns `adc_cs_n` to 1.
- R6: The reader is ready only when `adc_busy` is 0 and GUARD clock edges have passed since the later of two events: the last edge that saw `adc_busy` high, and the end of the last completed frame. With `start` held high, the next frame opens GUARD+1 cycles after `adc_busy` falls.
- R7: `abort_req` is honoured on an edge where the reader is shifting, at least 9 rising serial edges have occurred and the 16th falling edge has not yet happened. On that edge `adc_sclk` goes to 0 and `abort_done` pulses for one cycle. In chip-select framing `adc_cs_n` goes to 1. In frame-sync framing `adc_fs` pulses high for that cycle and `adc_cs_n` rises one cycle later. No `sample_valid` follows and `sample` keeps its previous value.
- R8: `abort_req` before the 9th rising serial edge has no effect: the frame completes and delivers its full word.
- R9: `dsp_mode` is sampled only when a frame is accepted. Changing it during a frame does not alter that frame's framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_mode | input | 1 | 1 = frame-sync framing, 0 = chip-select framing |
| start | input | 1 | Request a frame (level, taken when idle and ready) |
| abort_req | input | 1 | Request cancellation of the frame in progress |
| adc_busy | input | 1 | Converter busy indication |
| adc_sdo | input | 1 | Serial data from converter |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_cs_n | output | 1 | Active-low chip-select |
| adc_fs | output | 1 | Frame-sync pulse |
| sample | output | 16 | Last completed sample word |
| sample_valid | output | 1 | One-cycle strobe when `sample` updates |
| abort_done | output | 1 | One-cycle strobe when a frame is cancelled |

## Verification
Most internal faults reach the ports quickly:

- A wrong phase count or bit count shifts `adc_sclk` or the `adc_cs_n` release by whole cycles within the same frame.
- A corrupted shift register shows up only when `sample` is loaded, at the end of that frame.
- A wrong guard counter is invisible until the next held request, where `adc_cs_n` falls early or late relative to `adc_busy` falling.

The bench compares all outputs against its own behavioural model on every cycle, so each of these is reported in the first cycle where it diverges.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int WORD_W     = 16,
  parameter int DIV        = 2,
  parameter int CS_SETUP   = 3,
  parameter int FS_WIDTH   = 2,
  parameter int HOLD       = 2,
  parameter int GUARD      = 4,
  parameter int ABORT_RISE = 9,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsp_mode,
  input  logic              start,
  input  logic              abort_req,
  input  logic              adc_busy,
  input  logic              adc_sdo,
  output logic              adc_sclk,
  output logic              adc_cs_n,
  output logic              adc_fs,
  output logic [WORD_W-1:0] sample,
  output logic              sample_valid,
  output logic              abort_done
);
  localparam int BW = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_FSY, S_SHIFT, S_HOLD, S_ABRT} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt, gap;
  logic [BW-1:0]     nrise, nfall;
  logic [WORD_W-1:0] shreg;
  logic              mode;

  wire ready      = (gap == CNT_W'(GUARD)) && !adc_busy;
  wire tick       = cnt == CNT_W'(DIV - 1);
  wire frame_done = (st == S_HOLD) && (cnt == CNT_W'(HOLD - 1));
  wire abort_ok   = (st == S_SHIFT) && abort_req && (nrise >= BW'(ABORT_RISE));

  always_ff @(posedge clk) begin
    if (!rst_n)                  gap <= CNT_W'(GUARD);
    else if (frame_done || adc_busy) gap <= '0;
    else if (gap != CNT_W'(GUARD)) gap <= gap + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; mode <= 1'b0;
      nrise <= '0; nfall <= '0; shreg <= '0;
      adc_cs_n <= 1'b1; adc_fs <= 1'b0; adc_sclk <= 1'b0;
      sample <= '0; sample_valid <= 1'b0; abort_done <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      abort_done   <= 1'b0;
      case (st)
        S_IDLE: if (start && ready) begin
          adc_cs_n <= 1'b0; cnt <= '0; nrise <= '0; nfall <= '0;
          mode <= dsp_mode;
          st <= dsp_mode ? S_PRE : S_SHIFT;
        end
        S_PRE: if (cnt == CNT_W'(CS_SETUP - 1)) begin
          cnt <= '0; adc_fs <= 1'b1; st <= S_FSY;
        end else cnt <= cnt + 1'b1;
        S_FSY: if (cnt == CNT_W'(FS_WIDTH - 1)) begin
          cnt <= '0; adc_fs <= 1'b0; st <= S_SHIFT;
        end else cnt <= cnt + 1'b1;
        S_SHIFT: if (abort_ok) begin
          st <= S_ABRT; shreg <= '0; abort_done <= 1'b1; adc_sclk <= 1'b0;
          if (mode) adc_fs <= 1'b1;
          else      adc_cs_n <= 1'b1;
        end else if (tick) begin
          cnt <= '0;
          adc_sclk <= !adc_sclk;
          if (adc_sclk) begin
            shreg <= {shreg[WORD_W-2:0], adc_sdo};
            nfall <= nfall + 1'b1;
            if (nfall == BW'(WORD_W - 1)) st <= S_HOLD;
          end else nrise <= nrise + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_HOLD: if (frame_done) begin
          adc_cs_n <= 1'b1; sample <= shreg; sample_valid <= 1'b1; st <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_ABRT: begin
          adc_cs_n <= 1'b1; adc_fs <= 1'b0; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_sclk_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> !adc_cs_n);
  a_r3_fs_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    adc_fs |-> !adc_cs_n);
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  a_r5_valid_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $rose(adc_cs_n));
  a_r6_no_open_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> !$past(adc_busy));
  a_r7_abort_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |-> !sample_valid && $stable(sample));
  a_r7_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |=> adc_cs_n && !adc_fs && !abort_done);
endmodule

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;
  localparam int WORD_W = 16, DIV = 2, CS_SETUP = 3, FS_WIDTH = 2, HOLD = 2, GUARD = 4;
  localparam int ABORT_RISE = 9, BUSY_LAT = 2, CONV = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dsp_mode = 1'b0, start = 1'b0, abort_req = 1'b0, adc_busy = 1'b0, adc_sdo = 1'b0;
  logic adc_sclk, adc_cs_n, adc_fs, sample_valid, abort_done;
  logic [WORD_W-1:0] sample;

  adc_frame_reader #(.WORD_W(WORD_W), .DIV(DIV), .CS_SETUP(CS_SETUP), .FS_WIDTH(FS_WIDTH),
    .HOLD(HOLD), .GUARD(GUARD), .ABORT_RISE(ABORT_RISE), .CNT_W(8)) u_adc_frame_reader (
    .clk(clk), .rst_n(rst_n), .dsp_mode(dsp_mode), .start(start), .abort_req(abort_req),
    .adc_busy(adc_busy), .adc_sdo(adc_sdo), .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n),
    .adc_fs(adc_fs), .sample(sample), .sample_valid(sample_valid), .abort_done(abort_done));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  logic [WORD_W-1:0] word = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // converter model
  int rc = 0, fc = 0, btimer = 0;
  logic prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (adc_cs_n || adc_fs) begin rc = 0; fc = 0; end
    else if (adc_sclk && !prev_sclk) begin
      rc++;
      if (rc <= WORD_W) adc_sdo = word[WORD_W-rc];
    end else if (!adc_sclk && prev_sclk) begin
      fc++;
      if (fc == WORD_W) btimer = BUSY_LAT + CONV + 1;
    end
    prev_sclk = adc_sclk;
    if (btimer > 0) btimer--;
    adc_busy = (btimer > 0) && (btimer <= CONV);
  end

  // reference model
  int m_phase = 0, m_e = 0, m_D = 0, m_gap = GUARD;
  logic m_mode = 1'b0;
  logic e_cs = 1'b1, e_fs = 1'b0, e_sclk = 1'b0, e_valid = 1'b0, e_abort = 1'b0;
  logic [WORD_W-1:0] e_sample = '0;
  always @(posedge clk) begin
    int s_old, rises;
    bit rdy;
    cyc++;
    e_valid = 1'b0; e_abort = 1'b0;
    if (!rst_n) begin
      m_phase = 0; m_gap = GUARD; e_sample = '0;
    end else begin
      rdy = (m_gap == GUARD) && !adc_busy;
      if (m_phase == 0) begin
        if (start && rdy) begin
          m_phase = 1; m_e = 0; m_mode = dsp_mode;
          m_D = dsp_mode ? CS_SETUP + FS_WIDTH : 0;
        end
      end else if (m_phase == 2) m_phase = 0;
      else begin
        s_old = m_e - m_D;
        rises = (s_old >= 0) ? (s_old / DIV + 1) / 2 : 0;
        if (s_old >= 0 && s_old <= 2*WORD_W*DIV - 1 && abort_req && rises >= ABORT_RISE) begin
          m_phase = 2; e_abort = 1'b1;
        end else begin
          m_e++;
          if (m_e == m_D + 2*WORD_W*DIV + HOLD) begin
            m_phase = 0; e_valid = 1'b1; e_sample = word;
          end
        end
      end
      if (e_valid || adc_busy) m_gap = 0;
      else if (m_gap < GUARD) m_gap++;
    end
    case (m_phase)
      1: begin
        e_cs = 1'b0;
        e_fs = m_mode && m_e >= CS_SETUP && m_e < m_D;
        e_sclk = (m_e >= m_D && m_e < m_D + 2*WORD_W*DIV) ? (((m_e - m_D) / DIV) % 2 == 1) : 1'b0;
      end
      2: begin e_cs = !m_mode; e_fs = m_mode; e_sclk = 1'b0; end
      default: begin e_cs = 1'b1; e_fs = 1'b0; e_sclk = 1'b0; end
    endcase
  end

  // per-cycle comparison and event tracking
  bit got_valid = 0, got_abort = 0, saw_fs = 0;
  int busy_fall_cyc = 0, cs_fall_cyc = 0;
  logic prev_busy = 1'b0, prev_cs = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(adc_cs_n == e_cs, "R2 cs_n", adc_cs_n, e_cs);
      chk(adc_fs == e_fs, "R3 fs", adc_fs, e_fs);
      chk(adc_sclk == e_sclk, "R4 sclk", adc_sclk, e_sclk);
      chk(sample_valid == e_valid, "R5 sample_valid", sample_valid, e_valid);
      chk(sample == e_sample, "R5 sample", sample, e_sample);
      chk(abort_done == e_abort, "R7 abort_done", abort_done, e_abort);
      if (sample_valid) got_valid = 1;
      if (abort_done) got_abort = 1;
      if (adc_fs) saw_fs = 1;
      if (prev_busy && !adc_busy) busy_fall_cyc = cyc;
      if (prev_cs && !adc_cs_n) cs_fall_cyc = cyc;
    end
    prev_busy = adc_busy; prev_cs = adc_cs_n;
  end

  task automatic wait_end();
    got_valid = 0; got_abort = 0;
    for (int i = 0; i < 2000 && !got_valid && !got_abort; i++) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(adc_cs_n == 1'b1, "R1 cs_n", adc_cs_n, 1);
    chk({adc_fs, adc_sclk, sample_valid, abort_done} == 4'b0, "R1 strobes",
        {adc_fs, adc_sclk, sample_valid, abort_done}, 0);
    chk(sample == '0, "R1 sample", sample, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R4 R5 chip-select framing
    word = 16'hA5C3; pulse_start(); wait_end();
    chk(got_valid && sample == 16'hA5C3, "R5 spi word", sample, 16'hA5C3);

    // R6 back-to-back with start held
    word = 16'h8001;
    @(negedge clk) start = 1'b1;
    got_valid = 0;
    for (int i = 0; i < 2000 && !got_valid; i++) @(negedge clk);
    word = 16'h7FFE;
    got_valid = 0;
    for (int i = 0; i < 2000 && !got_valid; i++) @(negedge clk);
    start = 1'b0;
    chk(sample == 16'h7FFE, "R5 second word", sample, 16'h7FFE);
    chk(cs_fall_cyc - busy_fall_cyc == GUARD + 1, "R6 guard gap",
        cs_fall_cyc - busy_fall_cyc, GUARD + 1);
    repeat (30) @(negedge clk);

    // R3 R9 frame-sync framing, mode flipped mid-frame
    word = 16'h1234; saw_fs = 0; dsp_mode = 1'b1; pulse_start();
    repeat (3) @(negedge clk);
    dsp_mode = 1'b0;
    wait_end();
    chk(saw_fs && got_valid && sample == 16'h1234, "R9 latched mode", sample, 16'h1234);

    // R8 early abort ignored
    word = 16'h0F0F; pulse_start();
    abort_req = 1'b1;
    repeat (10) @(negedge clk);
    abort_req = 1'b0;
    wait_end();
    chk(got_valid && !got_abort, "R8 frame completes", got_abort, 0);
    chk(sample == 16'h0F0F, "R8 word", sample, 16'h0F0F);

    // R7 late abort, chip-select framing
    word = 16'hFFFF; pulse_start();
    repeat (39) @(negedge clk);
    abort_req = 1'b1;
    @(negedge clk) abort_req = 1'b0;
    wait_end();
    chk(got_abort && !got_valid, "R7 spi abort", got_valid, 0);
    chk(sample == 16'h0F0F, "R7 sample kept", sample, 16'h0F0F);

    // R7 late abort, frame-sync framing
    dsp_mode = 1'b1; pulse_start();
    repeat (44) @(negedge clk);
    abort_req = 1'b1;
    @(negedge clk) abort_req = 1'b0;
    wait_end();
    chk(got_abort && !got_valid, "R7 dsp abort", got_valid, 0);
    dsp_mode = 1'b0;

    // recovery after abort
    word = 16'h5AA5; pulse_start(); wait_end();
    chk(got_valid && sample == 16'h5AA5, "R5 after abort", sample, 16'h5AA5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected<20000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule